// File: doc/BRIEF.md
# Line Buffer Partition Configuration Selector

This block picks a memory arrangement for a display scaler's line buffer. It takes the source and destination line widths, the stored pixel depth, an alpha-plane enable, a 4:2:0 flag, and the vertical tap counts and rounded-up vertical scale ratios for luma and chroma. From these it works out how many whole lines ("partitions") each candidate arrangement can hold. It returns the first candidate that holds enough lines for the vertical filter, together with the luma and chroma partition counts for that candidate.

A request starts with a one-cycle `start_i` pulse and ends with a one-cycle `done_o` pulse. `busy_o` is high from the cycle after the request is accepted until the result is ready. All divisions share one restoring divider that produces one quotient bit per cycle. This keeps the area small, and a request takes a few hundred cycles. Results stay on the outputs until the next request completes.

Top module: `lb_part_sel`

## Requirements
- R1: The luma line width is min(vp_w_i, rec_w_i). The chroma line width is min(vp_c_w_i, rec_w_i). A width of 0 is used as 1.
- R2: depth_i selects the bits per component as follows: 0 gives 10, 1 gives 8, 2 gives 6 and 3 gives 12.
- R3: Luma and chroma words per line are ceil(width*bpc/72). Alpha words per line are ceil(luma width/6).
- R4: Memory sizes in words, given as luma/chroma/alpha, are: code 1 = 816/816/984, code 2 = 1088/1088/1312, code 3 = 4448/1904/2752, code 0 = 2752/2752/2752. Each partition count is floor(size/words per line).
- R5: When alpha_en_i is 1 and the alpha partition count is below the luma count, the luma count is lowered to the alpha count.
- R6: After the alpha limit, part_y_o and part_c_o are clamped to at most 64.
- R7: A code fits when both planes pass this test: taps <= parts - ratio + 2 when ratio > 2, and taps <= parts otherwise. The test uses the clamped counts.
- R8: Codes are tried in the order 1, 2, 3, 0. Code 3 is tried only when is420_i is 1. The first code that fits is returned on cfg_o.
- R9: When force_max_i is 1 the search is skipped. cfg_o is 3 if is420_i is 1 and 0 otherwise, and the counts shown are those of that code. err_o is 0.
- R10: When no code fits, cfg_o is 0 and err_o is 1. Otherwise err_o is 0.
- R11: done_o is a one-cycle pulse with busy_o low. start_i is ignored while busy_o is high. The outputs change only in the cycle that done_o is high.
- R12: After reset, busy_o, done_o, cfg_o, part_y_o, part_c_o and err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse; inputs are sampled when it is accepted |
| force_max_i | input | 1 | Skip the search and use the largest code for the format |
| is420_i | input | 1 | Source is 4:2:0 |
| alpha_en_i | input | 1 | Alpha plane is stored |
| depth_i | input | 2 | Stored pixel depth code |
| vp_w_i | input | WIDTH_W | Luma viewport width |
| vp_c_w_i | input | WIDTH_W | Chroma viewport width |
| rec_w_i | input | WIDTH_W | Output rectangle width |
| vtaps_i | input | TAP_W | Luma vertical taps |
| vtaps_c_i | input | TAP_W | Chroma vertical taps |
| vratio_i | input | RAT_W | Luma vertical ratio, rounded up |
| vratio_c_i | input | RAT_W | Chroma vertical ratio, rounded up |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Result valid pulse |
| cfg_o | output | 2 | Chosen memory configuration code |
| part_y_o | output | 7 | Luma partitions of the chosen code |
| part_c_o | output | 7 | Chroma partitions of the chosen code |
| err_o | output | 1 | No code satisfies the vertical filter |

## Verification
A wrong stored words-per-line value, a wrong memory size or a mis-stepped divider shows up as a wrong partition count on the next `done_o`. A wrong count can in turn change the chosen code. A wrong next-code step in the search returns a code out of order, or returns code 3 for a format that is not 4:2:0. That error is visible when the same request completes. A broken sequencer shows up at once in the per-cycle comparison of `busy_o` and `done_o`, either as a missing or repeated pulse or as a request that never ends.

// File: rtl/lbp_pkg.sv
package lbp_pkg;
  localparam int WORD_BITS      = 72;
  localparam int ALPHA_PER_WORD = 6;
  localparam int PART_CAP       = 64;
  localparam int MEM_W          = 13;

  typedef enum logic [1:0] {
    CFG0 = 2'd0,
    CFG1 = 2'd1,
    CFG2 = 2'd2,
    CFG3 = 2'd3
  } lb_cfg_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_EVAL
  } lbp_state_e;

  // plane: 0 luma, 1 chroma, 2 alpha
  function automatic logic [MEM_W-1:0] mem_words(lb_cfg_e cfg, logic [1:0] plane);
    logic [MEM_W-1:0] w;
    w = '0;
    unique case (cfg)
      CFG1: w = (plane == 2'd2) ? MEM_W'(984)  : MEM_W'(816);
      CFG2: w = (plane == 2'd2) ? MEM_W'(1312) : MEM_W'(1088);
      CFG3: w = (plane == 2'd0) ? MEM_W'(816 + 1088 + 3 * 848) :
                (plane == 2'd1) ? MEM_W'(816 + 1088) : MEM_W'(984 + 1312 + 456);
      CFG0: w = (plane == 2'd2) ? MEM_W'(984 + 1312 + 456) : MEM_W'(816 + 1088 + 848);
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [3:0] depth_bpc(logic [1:0] code);
    logic [3:0] b;
    unique case (code)
      2'd0: b = 4'd10;
      2'd1: b = 4'd8;
      2'd2: b = 4'd6;
      default: b = 4'd12;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lbp_div.sv
module lbp_div #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, quo_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [W:0]       trial, diff;
  logic             ge;

  assign trial = {rem_q, quo_q[W-1]};
  assign ge    = trial >= {1'b0, den_q};
  assign diff  = trial - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        den_q <= divisor_i;
        cnt_q <= CNT_W'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff[W-1:0] : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
endmodule

// File: rtl/lbp_ops.sv
module lbp_ops
  import lbp_pkg::*;
#(
  parameter int WIDTH_W = 14,
  parameter int DIV_W   = 18
) (
  input  logic [2:0]         op_i,
  input  lb_cfg_e            cfg_i,
  input  logic [WIDTH_W-1:0] lw_i,
  input  logic [WIDTH_W-1:0] lwc_i,
  input  logic [3:0]         bpc_i,
  input  logic [DIV_W-1:0]   words_y_i,
  input  logic [DIV_W-1:0]   words_c_i,
  input  logic [DIV_W-1:0]   words_a_i,
  output logic [DIV_W-1:0]   dividend_o,
  output logic [DIV_W-1:0]   divisor_o
);
  logic [DIV_W-1:0] bits_y, bits_c, pix_a;

  // pre-added terms turn the floor divider into a ceiling divider
  assign bits_y = DIV_W'(lw_i)  * DIV_W'(bpc_i) + DIV_W'(WORD_BITS - 1);
  assign bits_c = DIV_W'(lwc_i) * DIV_W'(bpc_i) + DIV_W'(WORD_BITS - 1);
  assign pix_a  = DIV_W'(lw_i) + DIV_W'(ALPHA_PER_WORD - 1);

  always_comb begin
    dividend_o = '0;
    divisor_o  = DIV_W'(1);
    unique case (op_i)
      3'd0: begin dividend_o = bits_y; divisor_o = DIV_W'(WORD_BITS); end
      3'd1: begin dividend_o = bits_c; divisor_o = DIV_W'(WORD_BITS); end
      3'd2: begin dividend_o = pix_a;  divisor_o = DIV_W'(ALPHA_PER_WORD); end
      3'd3: begin dividend_o = DIV_W'(mem_words(cfg_i, 2'd0)); divisor_o = words_y_i; end
      3'd4: begin dividend_o = DIV_W'(mem_words(cfg_i, 2'd1)); divisor_o = words_c_i; end
      3'd5: begin dividend_o = DIV_W'(mem_words(cfg_i, 2'd2)); divisor_o = words_a_i; end
      default: ;
    endcase
  end
endmodule

// File: rtl/lbp_fit.sv
module lbp_fit #(
  parameter int TAP_W  = 4,
  parameter int RAT_W  = 4,
  parameter int PART_W = 7
) (
  input  logic [TAP_W-1:0]  taps_i,
  input  logic [RAT_W-1:0]  ratio_i,
  input  logic [PART_W-1:0] parts_i,
  output logic              ok_o
);
  localparam int MAX_W = (TAP_W > RAT_W) ? ((TAP_W > PART_W) ? TAP_W : PART_W)
                                         : ((RAT_W > PART_W) ? RAT_W : PART_W);
  localparam int SUM_W = MAX_W + 2;

  logic [SUM_W-1:0] t, r, p;
  assign t = SUM_W'(taps_i);
  assign r = SUM_W'(ratio_i);
  assign p = SUM_W'(parts_i);

  // taps <= parts - ratio + 2, rearranged to avoid underflow
  assign ok_o = (r > SUM_W'(2)) ? (t + r <= p + SUM_W'(2)) : (t <= p);
endmodule

// File: rtl/lb_part_sel.sv
module lb_part_sel
  import lbp_pkg::*;
#(
  parameter int WIDTH_W = 14,
  parameter int TAP_W   = 4,
  parameter int RAT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               force_max_i,
  input  logic               is420_i,
  input  logic               alpha_en_i,
  input  logic [1:0]         depth_i,
  input  logic [WIDTH_W-1:0] vp_w_i,
  input  logic [WIDTH_W-1:0] vp_c_w_i,
  input  logic [WIDTH_W-1:0] rec_w_i,
  input  logic [TAP_W-1:0]   vtaps_i,
  input  logic [TAP_W-1:0]   vtaps_c_i,
  input  logic [RAT_W-1:0]   vratio_i,
  input  logic [RAT_W-1:0]   vratio_c_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [1:0]         cfg_o,
  output logic [6:0]         part_y_o,
  output logic [6:0]         part_c_o,
  output logic               err_o
);
  localparam int DIV_W  = WIDTH_W + 4;
  localparam int PART_W = $clog2(PART_CAP + 1);
  localparam int LANES  = 2;

  lbp_state_e state_q;
  lb_cfg_e    cfg_q;
  logic [2:0] op_q;

  logic [WIDTH_W-1:0] lw_q, lwc_q, lw_d, lwc_d, lw_min, lwc_min;
  logic [3:0]         bpc_q;
  logic               alpha_q, is420_q, force_q;
  logic [TAP_W-1:0]   taps_q  [LANES];
  logic [RAT_W-1:0]   ratio_q [LANES];

  logic [DIV_W-1:0] words_y_q, words_c_q, words_a_q;
  logic [DIV_W-1:0] py_raw_q, pc_raw_q, pa_raw_q, py_alpha;
  logic [PART_W-1:0] parts_cl [LANES];
  logic [LANES-1:0]  fit_ok;
  logic              all_ok;

  logic             div_start, div_done;
  logic [DIV_W-1:0] dividend, divisor, quot;

  logic             done_q, err_q;
  logic [1:0]       cfg_out_q;
  logic [PART_W-1:0] py_out_q, pc_out_q;

  // line widths, zero treated as one
  assign lw_min  = (vp_w_i   < rec_w_i) ? vp_w_i   : rec_w_i;
  assign lwc_min = (vp_c_w_i < rec_w_i) ? vp_c_w_i : rec_w_i;
  assign lw_d    = (lw_min  == '0) ? WIDTH_W'(1) : lw_min;
  assign lwc_d   = (lwc_min == '0) ? WIDTH_W'(1) : lwc_min;

  assign div_start = (state_q == ST_ISSUE);

  lbp_ops #(.WIDTH_W(WIDTH_W), .DIV_W(DIV_W)) u_ops (
    .op_i      (op_q),
    .cfg_i     (cfg_q),
    .lw_i      (lw_q),
    .lwc_i     (lwc_q),
    .bpc_i     (bpc_q),
    .words_y_i (words_y_q),
    .words_c_i (words_c_q),
    .words_a_i (words_a_q),
    .dividend_o(dividend),
    .divisor_o (divisor)
  );

  lbp_div #(.W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (div_start),
    .dividend_i(dividend),
    .divisor_i (divisor),
    .done_o    (div_done),
    .quot_o    (quot)
  );

  // alpha limit then cap
  assign py_alpha = (alpha_q && (pa_raw_q < py_raw_q)) ? pa_raw_q : py_raw_q;

  function automatic logic [PART_W-1:0] cap_parts(logic [DIV_W-1:0] v);
    return (v > DIV_W'(PART_CAP)) ? PART_W'(PART_CAP) : v[PART_W-1:0];
  endfunction

  assign parts_cl[0] = cap_parts(py_alpha);
  assign parts_cl[1] = cap_parts(pc_raw_q);

  for (genvar g = 0; g < LANES; g++) begin : g_fit
    lbp_fit #(.TAP_W(TAP_W), .RAT_W(RAT_W), .PART_W(PART_W)) u_fit (
      .taps_i (taps_q[g]),
      .ratio_i(ratio_q[g]),
      .parts_i(parts_cl[g]),
      .ok_o   (fit_ok[g])
    );
  end

  assign all_ok = &fit_ok;

  function automatic lb_cfg_e next_cfg(lb_cfg_e c, logic yuv420);
    lb_cfg_e n;
    unique case (c)
      CFG1:    n = CFG2;
      CFG2:    n = yuv420 ? CFG3 : CFG0;
      default: n = CFG0;
    endcase
    return n;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cfg_q      <= CFG1;
      op_q       <= '0;
      lw_q       <= '0;
      lwc_q      <= '0;
      bpc_q      <= '0;
      alpha_q    <= 1'b0;
      is420_q    <= 1'b0;
      force_q    <= 1'b0;
      taps_q[0]  <= '0;
      taps_q[1]  <= '0;
      ratio_q[0] <= '0;
      ratio_q[1] <= '0;
      words_y_q  <= '0;
      words_c_q  <= '0;
      words_a_q  <= '0;
      py_raw_q   <= '0;
      pc_raw_q   <= '0;
      pa_raw_q   <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      cfg_out_q  <= '0;
      py_out_q   <= '0;
      pc_out_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            lw_q       <= lw_d;
            lwc_q      <= lwc_d;
            bpc_q      <= depth_bpc(depth_i);
            alpha_q    <= alpha_en_i;
            is420_q    <= is420_i;
            force_q    <= force_max_i;
            taps_q[0]  <= vtaps_i;
            taps_q[1]  <= vtaps_c_i;
            ratio_q[0] <= vratio_i;
            ratio_q[1] <= vratio_c_i;
            cfg_q      <= force_max_i ? (is420_i ? CFG3 : CFG0) : CFG1;
            op_q       <= 3'd0;
            state_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (div_done) begin
            unique case (op_q)
              3'd0: words_y_q <= quot;
              3'd1: words_c_q <= quot;
              3'd2: words_a_q <= quot;
              3'd3: py_raw_q  <= quot;
              3'd4: pc_raw_q  <= quot;
              default: pa_raw_q <= quot;
            endcase
            if (op_q == 3'd5) begin
              state_q <= ST_EVAL;
            end else begin
              op_q    <= op_q + 3'd1;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_EVAL: begin
          if (force_q || all_ok || (cfg_q == CFG0)) begin
            done_q    <= 1'b1;
            cfg_out_q <= cfg_q;
            py_out_q  <= parts_cl[0];
            pc_out_q  <= parts_cl[1];
            err_q     <= !force_q && !all_ok;
            state_q   <= ST_IDLE;
          end else begin
            cfg_q   <= next_cfg(cfg_q, is420_q);
            op_q    <= 3'd3;
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign cfg_o    = cfg_out_q;
  assign part_y_o = 7'(py_out_q);
  assign part_c_o = 7'(pc_out_q);
  assign err_o    = err_q;
endmodule

// File: rtl/lbp_chk.sv
module lbp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       is420_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] cfg_o,
  input logic [6:0] part_y_o,
  input logic [6:0] part_c_o,
  input logic       err_o
);
  logic fmt420_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fmt420_q <= 1'b0;
    else if (start_i && !busy_o) fmt420_q <= is420_i;
  end

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(cfg_o) && $stable(part_y_o) && $stable(part_c_o) && $stable(err_o)));

  assert_part_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (part_y_o <= 7'd64 && part_c_o <= 7'd64));

  assert_cfg3_fmt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cfg_o == 2'd3) |-> fmt420_q);

  assert_err_fallback_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (cfg_o == 2'd0));
endmodule

bind lb_part_sel lbp_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .is420_i (is420_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .cfg_o   (cfg_o),
  .part_y_o(part_y_o),
  .part_c_o(part_c_o),
  .err_o   (err_o)
);

// File: tb/tb_lb_part_sel.sv
module tb_lb_part_sel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, force_max_i = 1'b0, is420_i = 1'b0, alpha_en_i = 1'b0;
  logic [1:0]  depth_i = '0;
  logic [13:0] vp_w_i = '0, vp_c_w_i = '0, rec_w_i = '0;
  logic [3:0]  vtaps_i = '0, vtaps_c_i = '0, vratio_i = '0, vratio_c_i = '0;
  logic        busy_o, done_o, err_o;
  logic [1:0]  cfg_o;
  logic [6:0]  part_y_o, part_c_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  lb_part_sel dut (.*);

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int bpc_of(int d);
    case (d)
      0: return 10;
      1: return 8;
      2: return 6;
      default: return 12;
    endcase
  endfunction

  function automatic int mem_of(int cfg, int plane);
    int t [4][3] = '{'{2752, 2752, 2752}, '{816, 816, 984},
                     '{1088, 1088, 1312}, '{4448, 1904, 2752}};
    return t[cfg][plane];
  endfunction

  function automatic bit fits(int taps, int r, int p);
    if (r > 2) return taps <= p - r + 2;
    return taps <= p;
  endfunction

  function automatic void model(int vw, int vcw, int ow, int dep, int ae, int i420, int fm,
                                int vt, int vtc, int r, int rc,
                                output int cfg, output int py, output int pc, output int e);
    int ly, lc, b, wy, wc, wa, pa;
    int order[$];
    ly = (vw < ow) ? vw : ow;  if (ly == 0) ly = 1;
    lc = (vcw < ow) ? vcw : ow; if (lc == 0) lc = 1;
    b  = bpc_of(dep);
    wy = (ly * b + 71) / 72;
    wc = (lc * b + 71) / 72;
    wa = (ly + 5) / 6;
    if (fm != 0) order.push_back(i420 != 0 ? 3 : 0);
    else begin
      order.push_back(1); order.push_back(2);
      if (i420 != 0) order.push_back(3);
      order.push_back(0);
    end
    e = 0;
    foreach (order[k]) begin
      cfg = order[k];
      py = mem_of(cfg, 0) / wy;
      pc = mem_of(cfg, 1) / wc;
      pa = mem_of(cfg, 2) / wa;
      if (ae != 0 && pa < py) py = pa;
      if (py > 64) py = 64;
      if (pc > 64) pc = 64;
      if (fm != 0) break;
      if (fits(vt, r, py) && fits(vtc, rc, pc)) break;
      if (cfg == 0) e = 1;
    end
  endfunction

  task automatic run_case(string tag, int vw, int vcw, int ow, int dep, int ae, int i420,
                          int fm, int vt, int vtc, int r, int rc, bit poke = 0);
    int ecfg, epy, epc, ee, n;
    model(vw, vcw, ow, dep, ae, i420, fm, vt, vtc, r, rc, ecfg, epy, epc, ee);
    @(negedge clk_i);
    vp_w_i = 14'(vw); vp_c_w_i = 14'(vcw); rec_w_i = 14'(ow);
    depth_i = 2'(dep); alpha_en_i = 1'(ae); is420_i = 1'(i420); force_max_i = 1'(fm);
    vtaps_i = 4'(vt); vtaps_c_i = 4'(vtc); vratio_i = 4'(r); vratio_c_i = 4'(rc);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 4000) begin
      chk(busy_o == 1'b1, "R11", "busy while running", busy_o, 1);
      if (poke && n == 30) begin
        vp_w_i = 14'd1; rec_w_i = 14'd1; force_max_i = 1'b1; is420_i = 1'b1;
        start_i = 1'b1;
      end else start_i = 1'b0;
      @(negedge clk_i);
      n++;
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, tag, "done seen", done_o, 1);
    chk(busy_o == 1'b0, "R11", "idle at done", busy_o, 0);
    chk(cfg_o == 2'(ecfg), tag, "cfg", cfg_o, ecfg);
    chk(part_y_o == 7'(epy), tag, "part_y", part_y_o, epy);
    chk(part_c_o == 7'(epc), tag, "part_c", part_c_o, epc);
    chk(err_o == 1'(ee), tag, "err", err_o, ee);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R11", "done one cycle", done_o, 0);
    chk(cfg_o == 2'(ecfg) && part_y_o == 7'(epy), "R11", "held after done", cfg_o, ecfg);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0, "R12", "reset busy/done", {busy_o, done_o}, 0);
    chk(cfg_o == 0 && err_o == 0, "R12", "reset cfg/err", {cfg_o, err_o}, 0);
    chk(part_y_o == 0 && part_c_o == 0, "R12", "reset parts", part_y_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run_case("R3",  640, 320, 640, 1, 0, 0, 0, 4, 4, 1, 1);
    run_case("R1",  0, 0, 100, 1, 0, 0, 0, 2, 2, 1, 1);
    run_case("R6",  50, 25, 50, 3, 1, 0, 0, 2, 2, 1, 1);
    run_case("R1",  1920, 960, 800, 1, 0, 0, 0, 6, 6, 1, 1);
    run_case("R2",  1920, 960, 1920, 0, 0, 0, 0, 2, 2, 1, 1);
    run_case("R2",  1920, 960, 1920, 2, 0, 0, 0, 2, 2, 1, 1);
    run_case("R2",  1920, 960, 1920, 3, 0, 0, 0, 2, 2, 1, 1);
    run_case("R5",  3000, 1500, 3000, 2, 1, 0, 0, 2, 2, 1, 1);
    run_case("R4",  4096, 2048, 4096, 1, 0, 0, 0, 2, 2, 1, 1);
    run_case("R8",  4096, 2048, 4096, 3, 0, 1, 0, 2, 2, 1, 1);
    run_case("R8",  4096, 2048, 4096, 3, 0, 0, 0, 2, 2, 1, 1);
    run_case("R7",  640, 640, 640, 1, 0, 0, 0, 8, 2, 4, 1);
    run_case("R7",  640, 640, 640, 1, 0, 0, 0, 8, 2, 6, 1);
    run_case("R7",  640, 640, 640, 1, 0, 0, 0, 2, 8, 1, 6);
    run_case("R9",  640, 320, 640, 1, 0, 1, 1, 2, 2, 1, 1);
    run_case("R9",  640, 320, 640, 1, 1, 0, 1, 15, 15, 9, 9);
    run_case("R10", 8192, 4096, 8192, 3, 0, 0, 0, 3, 2, 1, 1);
    run_case("R10", 8192, 8192, 8192, 3, 0, 1, 0, 2, 15, 1, 1);
    run_case("R11", 4096, 2048, 4096, 1, 0, 0, 0, 2, 2, 1, 1, 1);
    run_case("R11", 2000, 1000, 2000, 0, 1, 1, 0, 4, 3, 3, 2);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule